// File: doc/BRIEF.md
# Motor Bridge Serial Register Target

This block is the two-wire serial target that sits in front of a small motor bridge controller. It oversamples the SCL and SDA lines with the system clock and finds START and STOP conditions on the filtered lines. It then decodes a 7-bit target address and moves bytes MSB first, with an acknowledge after each one. A host selects one of two registers by writing a sub-address byte. It can then write data bytes at once, or issue a repeated START and read the selected register back.

The first register holds the drive setting: a six-bit voltage setpoint in bits 7..2 and the two bridge direction bits in bits 1..0. The second register reports fault status. Its status bits come from the fault logic beside this block and cannot be written. Writing a one to its top bit raises a one-clock clear request toward that logic.

Two address pins each sense one of three levels, so nine copies can share one bus. The pin levels are captured while reset is asserted and are held from then on. The target drives SDA only as an open-drain pull-down enable.

Top module: `mdrv_i2c_regs`

## Requirements
- R1: The target answers the 7-bit address 0x60 + N. As 8-bit bus bytes this is write 0xC0 + 2N and read 0xC1 + 2N. N = 3*d(A1) + d(A0), where the digit d is 0 for a low pin, 1 for an open pin and 2 for a high pin. Each strap input codes its pin as 2'b00 = low, 2'b01 = high, 2'b1x = open.
- R2: The strap inputs are captured on every clock edge while rst_n is low. Changes made after reset is released have no effect on the address.
- R3: The target does not acknowledge an address that is not its own, and this includes the general call address 0x00. It leaves SDA released during that ninth clock and ignores the bus until the next START.
- R4: A write consists of the address byte with R/W = 0, then a sub-address byte, then data bytes. Bit 0 of the sub-address byte selects the register: 0 = control, 1 = fault. The target acknowledges each byte by pulling SDA low for the ninth clock.
- R5: The control register resets to 0x00 and drives ctrl_o. It changes only when the acknowledge clock of a complete data byte ends. A byte cut short by a STOP leaves it unchanged.
- R6: The register pointer toggles between 0 and 1 after every data byte, whether written or read.
- R7: A read starts with a sub-address write, then a repeated START and the read address. The target returns the register at the pointer, MSB first. A master ACK makes it continue with the next register. A master NACK ends the transfer with SDA released.
- R8: The fault register reads as {3'b000, ilimit, ots, uvlo, ocp, any}. The inputs flt_flags_i[3:0] are {ilimit, ots, uvlo, ocp}, and "any" is their OR. Bit 7 always reads 0.
- R9: A data byte written to the fault register with bit 7 set raises flt_clear_o for exactly one clock. A byte with bit 7 clear raises no pulse. Neither kind of write changes the value read back from the fault register.
- R10: Each line passes through a two-flop synchroniser and a filter that accepts a new level only after it has held for FILT_LEN clocks. An SCL pulse of one clock does not count as a bit.
- R11: SDA is released (sda_oe_o = 0) while the target is idle and after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset; strap capture window |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| a1_strap_i | input | 2 | Sensed level of address pin 1 (00 low, 01 high, 1x open) |
| a0_strap_i | input | 2 | Sensed level of address pin 0 (00 low, 01 high, 1x open) |
| flt_flags_i | input | 4 | Fault status {ilimit, ots, uvlo, ocp} |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ctrl_o | output | 8 | Control register: setpoint[7:2], dir_b[1], dir_a[0] |
| flt_clear_o | output | 1 | One-clock clear request for the fault logic |

## Verification
The address decoder is tried with three strap pairs: both open, high over low, and low over high. Each pair hits a different row of the three-level mapping, and an order swap or a wrong digit weight would acknowledge the wrong byte. Writes go to each register on its own and as two-byte auto-increment bursts. Reads are tried with both master ACK and master NACK, which separates pointer wrap from transfer end. Further patterns are clear-bit writes with bit 7 set and with bit 7 clear, a byte cut short by STOP, foreign and general-call addresses, strap changes after reset, and a one-clock SCL pulse inside every bit of a byte, which exercises the filter.

// File: rtl/mdrv_i2c_pkg.sv
package mdrv_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WBYTE,
      ST_WACK,
      ST_RBYTE,
      ST_RACK
   } bus_st_e;

   // Three-level strap code to address digit: low 0, open 1, high 2
   function automatic logic [1:0] strap_digit(input logic [1:0] code);
      if (code[1])
         return 2'd1;
      else if (code[0])
         return 2'd2;
      else
         return 2'd0;
   endfunction

endpackage

// File: rtl/mdrv_line_filter.sv
module mdrv_line_filter #(
   parameter int LINES    = 2,
   parameter int SYNC_LEN = 2,
   parameter int FILT_LEN = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw_i,
   output logic [LINES-1:0] clean_o
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_LEN-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_LEN-2:0], raw_i[g]};
      end

      if (FILT_LEN == 0) begin : g_bypass
         assign clean_o[g] = sync_q[SYNC_LEN-1];
      end else begin : g_filter
         logic          lvl_q;
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= 1'b1;
               run_q <= '0;
            end else if (sync_q[SYNC_LEN-1] == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
               lvl_q <= sync_q[SYNC_LEN-1];
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
         assign clean_o[g] = lvl_q;
      end
   end
endmodule

// File: rtl/mdrv_addr_strap.sv
module mdrv_addr_strap #(
   parameter logic [6:0] BASE7 = 7'h60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] a1_code_i,
   input  logic [1:0] a0_code_i,
   output logic [3:0] idx_o,
   output logic [6:0] own_addr_o
);
   import mdrv_i2c_pkg::*;

   logic [3:0] idx_q;
   logic [3:0] idx_d;

   assign idx_d = 4'(strap_digit(a1_code_i)) * 4'd3 + 4'(strap_digit(a0_code_i));

   // Capture only while reset is held; no reset value on purpose
   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= idx_d;
   end

   assign idx_o      = idx_q;
   assign own_addr_o = BASE7 + 7'(idx_q);
endmodule

// File: rtl/mdrv_reg_bank.sv
module mdrv_reg_bank #(
   parameter int DW     = 8,
   parameter int FLAG_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DW-1:0]     wr_data_i,
   input  logic              rd_sel_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [DW-1:0]     rd_data_o,
   output logic [DW-1:0]     ctrl_o,
   output logic              clr_o
);
   localparam int PAD_W = DW - FLAG_W - 1;

   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] fault_view;
   logic          clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         clr_q  <= 1'b0;
      end else begin
         clr_q <= wr_en_i & wr_sel_i & wr_data_i[DW-1];
         if (wr_en_i && !wr_sel_i) ctrl_q <= wr_data_i;
      end
   end

   assign fault_view = {{PAD_W{1'b0}}, flags_i, |flags_i};
   assign rd_data_o  = rd_sel_i ? fault_view : ctrl_q;
   assign ctrl_o     = ctrl_q;
   assign clr_o      = clr_q;
endmodule

// File: rtl/mdrv_i2c_regs.sv
module mdrv_i2c_regs #(
   parameter int         SYNC_LEN = 2,
   parameter int         FILT_LEN = 3,
   parameter logic [6:0] BASE7    = 7'h60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [1:0] a1_strap_i,
   input  logic [1:0] a0_strap_i,
   input  logic [3:0] flt_flags_i,
   output logic       sda_oe_o,
   output logic [7:0] ctrl_o,
   output logic       flt_clear_o
);
   import mdrv_i2c_pkg::*;

   localparam int DW = 8;
   localparam int BW = $clog2(DW + 1);

   if (SYNC_LEN < 2) begin : g_bad_sync
      $error("SYNC_LEN must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("FILT_LEN must not be negative");
   end

   logic [1:0] clean;
   logic       scl_f, sda_f, scl_q, sda_q;
   logic       scl_rise, scl_fall, bus_start, bus_stop;
   logic [3:0] addr_idx;
   logic [6:0] own_addr;

   bus_st_e       state;
   logic [BW-1:0] bitcnt;
   logic [DW-1:0] shreg;
   logic          rw_q, sub_pend, nack_q, ptr, oe_q;
   logic          wr_en, fsm_idle;
   logic [DW-1:0] rd_data;

   mdrv_line_filter #(.LINES(2), .SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}), .clean_o(clean));

   mdrv_addr_strap #(.BASE7(BASE7)) u_strap (
      .clk(clk), .rst_n(rst_n), .a1_code_i(a1_strap_i), .a0_code_i(a0_strap_i),
      .idx_o(addr_idx), .own_addr_o(own_addr));

   assign scl_f = clean[1];
   assign sda_f = clean[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise  = scl_f & ~scl_q;
   assign scl_fall  = ~scl_f & scl_q;
   assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
   assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         rw_q     <= 1'b0;
         sub_pend <= 1'b0;
         nack_q   <= 1'b0;
         ptr      <= 1'b0;
         oe_q     <= 1'b0;
      end else if (bus_start) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         oe_q   <= 1'b0;
      end else if (bus_stop) begin
         state <= ST_IDLE;
         oe_q  <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_WBYTE: begin
               if (scl_rise) begin
                  shreg  <= {shreg[DW-2:0], sda_f};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == BW'(DW)) begin
                  bitcnt <= '0;
                  if (state == ST_WBYTE) begin
                     state <= ST_WACK;
                     oe_q  <= 1'b1;
                  end else if (shreg[DW-1:1] == own_addr) begin
                     state <= ST_AACK;
                     rw_q  <= shreg[0];
                     oe_q  <= 1'b1;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_AACK: if (scl_fall) begin
               if (rw_q) begin
                  state <= ST_RBYTE;
                  oe_q  <= ~rd_data[DW-1];
                  shreg <= {rd_data[DW-2:0], 1'b0};
               end else begin
                  state    <= ST_WBYTE;
                  oe_q     <= 1'b0;
                  sub_pend <= 1'b1;
               end
            end
            ST_WACK: if (scl_fall) begin
               state <= ST_WBYTE;
               oe_q  <= 1'b0;
               if (sub_pend) begin
                  ptr      <= shreg[0];
                  sub_pend <= 1'b0;
               end else begin
                  ptr <= ~ptr;
               end
            end
            ST_RBYTE: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall) begin
                  if (bitcnt == BW'(DW)) begin
                     bitcnt <= '0;
                     oe_q   <= 1'b0;
                     ptr    <= ~ptr;
                     state  <= ST_RACK;
                  end else begin
                     oe_q  <= ~shreg[DW-1];
                     shreg <= {shreg[DW-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_q <= sda_f;
               end else if (scl_fall) begin
                  if (nack_q) begin
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_RBYTE;
                     oe_q  <= ~rd_data[DW-1];
                     shreg <= {rd_data[DW-2:0], 1'b0};
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_en    = (state == ST_WACK) & scl_fall & ~sub_pend & ~bus_start & ~bus_stop;
   assign fsm_idle = (state == ST_IDLE);

   mdrv_reg_bank #(.DW(DW), .FLAG_W(4)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(ptr), .wr_data_i(shreg),
      .rd_sel_i(ptr), .flags_i(flt_flags_i), .rd_data_o(rd_data), .ctrl_o(ctrl_o),
      .clr_o(flt_clear_o));

   assign sda_oe_o = oe_q;
endmodule

// File: rtl/mdrv_i2c_regs_chk.sv
module mdrv_i2c_regs_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_oe,
   input logic [7:0] ctrl,
   input logic       clr,
   input logic       wr_en,
   input logic       bus_stop,
   input logic       idle,
   input logic [3:0] addr_idx
);
   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) addr_idx <= 4'd8); // R1
   AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $stable(addr_idx)); // R2
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(ctrl)); // R5
   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) clr |=> !clr); // R9
   AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) clr |-> $past(wr_en)); // R9
   AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !sda_oe); // R11
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) bus_stop |=> !sda_oe); // R11
endmodule

bind mdrv_i2c_regs mdrv_i2c_regs_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .ctrl(ctrl_o), .clr(flt_clear_o),
   .wr_en(wr_en), .bus_stop(bus_stop), .idle(fsm_idle), .addr_idx(addr_idx));

// File: tb/mdrv_i2c_regs_tb.sv
module mdrv_i2c_regs_tb;
   localparam int Q = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] a1_strap = 2'b10;
   logic [1:0] a0_strap = 2'b10;
   logic [3:0] flags = 4'b0000;
   logic       sda_oe;
   logic [7:0] ctrl;
   logic       clr;
   logic       sda_bus;

   int n_chk = 0;
   int n_fail = 0;
   int clr_cycles = 0;
   int clr_rises = 0;
   logic clr_prev = 1'b0;
   bit done = 1'b0;

   assign sda_bus = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   mdrv_i2c_regs u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .a1_strap_i(a1_strap), .a0_strap_i(a0_strap), .flt_flags_i(flags),
      .sda_oe_o(sda_oe), .ctrl_o(ctrl), .flt_clear_o(clr));

   always @(posedge clk) begin
      if (rst_n && clr) clr_cycles <= clr_cycles + 1;
      if (rst_n && clr && !clr_prev) clr_rises <= clr_rises + 1;
      clr_prev <= clr;
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      wq(6);
      rst_n = 1'b1;
      wq(4);
   endtask

   task automatic wbit(input logic b, input bit glitch);
      sda_m = b;
      if (glitch) begin
         wq(4); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 5);
      end else begin
         wq(Q);
      end
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic rbit(output logic b);
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      b = sda_bus; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bstart();
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bstop();
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(2 * Q);
   endtask

   task automatic send(input logic [7:0] b, output logic acked, input bit glitch = 1'b0);
      logic a;
      for (int i = 7; i >= 0; i--) wbit(b[i], glitch);
      rbit(a);
      acked = !a;
   endtask

   task automatic recv(output logic [7:0] d, input logic master_ack);
      for (int i = 7; i >= 0; i--) rbit(d[i]);
      wbit(!master_ack, 1'b0);
   endtask

   // R1 R4 R5: write the control register at strap index 4
   task automatic t_write_ctrl();
      logic a0, a1, a2;
      bstart(); send(8'hC8, a0); send(8'h00, a1); send(8'hA5, a2); bstop();
      chk("R1 own address acked", a0, 1);
      chk("R4 sub-address and data acked", {a1, a2}, 2'b11);
      chk("R5 control updated", ctrl, 8'hA5);
      chk("R11 released after STOP", sda_oe, 0);
   endtask

   // R6 R7 R8: read control then wrap to fault, NACK ends
   task automatic t_read_wrap();
      logic a0, a1, a2;
      logic [7:0] d0, d1;
      flags = 4'b0101;
      bstart(); send(8'hC8, a0); send(8'h00, a1);
      bstart(); send(8'hC9, a2);
      recv(d0, 1'b1); recv(d1, 1'b0);
      chk("R7 SDA released after NACK", sda_oe, 0);
      bstop();
      chk("R7 read address acked", {a0, a1, a2}, 3'b111);
      chk("R7 first read is control", d0, 8'hA5);
      chk("R6 R8 pointer wrapped to fault value", d1, 8'h0B);
   endtask

   // R6 R9: burst to fault then control, bit 7 clear
   task automatic t_autoinc_write();
      logic a0, a1, a2, a3;
      int r0;
      r0 = clr_rises;
      bstart(); send(8'hC8, a0); send(8'h01, a1); send(8'h1F, a2); send(8'h3C, a3); bstop();
      chk("R6 second byte lands in control", ctrl, 8'h3C);
      chk("R9 no clear pulse without bit 7", clr_rises - r0, 0);
   endtask

   // R9 R8: clear request and fault read-back unchanged
   task automatic t_clear();
      logic a0, a1, a2, a3, a4;
      logic [7:0] d;
      int r0, c0;
      r0 = clr_rises; c0 = clr_cycles;
      bstart(); send(8'hC8, a0); send(8'h01, a1); send(8'hFF, a2); bstop();
      chk("R9 one clear pulse", clr_rises - r0, 1);
      chk("R9 clear pulse one clock wide", clr_cycles - c0, 1);
      bstart(); send(8'hC8, a3); send(8'h01, a4);
      bstart(); send(8'hC9, a0); recv(d, 1'b0); bstop();
      chk("R8 R9 fault view ignores write, bit 7 zero", d, 8'h0B);
      flags = 4'b0000;
      bstart(); send(8'hC8, a3); send(8'h01, a4);
      bstart(); send(8'hC9, a0); recv(d, 1'b0); bstop();
      chk("R8 no flags reads zero", d, 8'h00);
   endtask

   // R3: foreign and general call addresses ignored
   task automatic t_wrong_addr();
      logic a0, a1, a2, a3;
      bstart(); send(8'hC2, a0); send(8'h00, a1); send(8'h77, a2); bstop();
      chk("R3 foreign address not acked", a0, 0);
      chk("R3 following bytes not acked", a1 | a2, 0);
      chk("R3 control untouched", ctrl, 8'h3C);
      bstart(); send(8'h00, a3); bstop();
      chk("R3 general call not acked", a3, 0);
   endtask

   // R5: byte cut by STOP is discarded
   task automatic t_abort();
      logic a0, a1;
      bstart(); send(8'hC8, a0); send(8'h00, a1);
      for (int i = 0; i < 4; i++) wbit(1'b1, 1'b0);
      bstop();
      chk("R5 partial byte discarded", ctrl, 8'h3C);
   endtask

   // R2: strap change after reset has no effect
   task automatic t_strap_change();
      logic a0, a1;
      a1_strap = 2'b00; a0_strap = 2'b00;
      wq(10);
      bstart(); send(8'hC0, a0); bstop();
      bstart(); send(8'hC8, a1); bstop();
      chk("R2 new strap address ignored", a0, 0);
      chk("R2 latched address still answers", a1, 1);
   endtask

   // R10: one-clock SCL pulses inside every bit
   task automatic t_glitch();
      logic a0, a1, a2;
      bstart(); send(8'hC8, a0); send(8'h00, a1); send(8'h5A, a2, 1'b1); bstop();
      chk("R10 glitched byte written intact", ctrl, 8'h5A);
   endtask

   // R1 R2 R5: other strap rows after a fresh reset
   task automatic t_other_idx();
      logic a0, a1, a2, a3, a4;
      a1_strap = 2'b01; a0_strap = 2'b00;
      do_reset();
      chk("R5 reset clears control", ctrl, 8'h00);
      bstart(); send(8'hCC, a0); send(8'h00, a1); send(8'h81, a2); bstop();
      bstart(); send(8'hC8, a3); bstop();
      chk("R1 high/low strap answers 0xCC", a0, 1);
      chk("R1 old address no longer answers", a3, 0);
      chk("R4 R5 write at 0xCC", ctrl, 8'h81);
      a1_strap = 2'b00; a0_strap = 2'b01;
      do_reset();
      bstart(); send(8'hC4, a4); bstop();
      chk("R1 low/high strap answers 0xC4", a4, 1);
   endtask

   initial begin
      do_reset();
      chk("R5 reset control", ctrl, 8'h00);
      chk("R11 reset SDA released", sda_oe, 0);
      chk("R9 reset clear low", clr, 0);
      t_write_ctrl();
      t_read_wrap();
      t_autoinc_write();
      t_clear();
      t_wrong_addr();
      t_abort();
      t_strap_change();
      t_glitch();
      t_other_idx();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule